// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for traffic. It holds clock enable high and sends no-operation for a programmable settling time. It then closes every bank with one precharge-all, issues a programmable number of auto-refresh commands, and writes the mode register from the burst and latency settings on its inputs. If enabled, it then writes the extended mode register, which carries the output drive strength and the size of the array kept alive during self refresh. Each command is one clock long, and the gaps that follow are parameters counted in clocks.

Once the last register write has had its recovery time, the block raises `init_done`. From then on the pins follow the normal controller's command inputs directly, with no added register stage. Before that point those inputs have no effect. The configuration inputs are plain levels. They are read in the cycle in which the matching register write is on the pins, and they must be held stable until `init_done` rises. There is no data stream and no handshake.

Top module: `sdram_boot_seq`

## Requirements
- R1: During reset and for the first STABLE_CYC cycles after reset is released (cycles 0 to STABLE_CYC-1), `sd_cke` is 1 and the command {cs_n,ras_n,cas_n,we_n} is NOP (0111).
- R2: In cycle STABLE_CYC, a precharge-all (0010) is driven with `sd_addr[10]`=1.
- R3: REF_CNT auto-refresh commands (0001) follow. The first is T_RP cycles after the precharge-all, and each later one is T_RC cycles after the one before.
- R4: The mode register write (0000 with `sd_ba`=00) comes T_RC cycles after the last refresh. Its address bits are: A9 = single-write, A6..A4 = latency, A3 = interleave, A2..A0 = burst length.
- R5: In the mode register write, address bits A11, A10, A8 and A7 are 0.
- R6: When `xm_enable`=1, the extended register write (0000 with `sd_ba`=10) comes T_MRD cycles after the mode register write. Its only non-zero address bits are A5 = `xm_half_drive` and A2..A0 = array size code. The code is 000 for full, 001 for half and 010 for quarter, selected by `xm_array_sel` = 0, 1 or 2.
- R7: `xm_array_sel`=3 encodes as 000 (full array).
- R8: When `xm_enable`=0, no extended register write is issued.
- R9: `init_done` rises exactly T_MRD cycles after the last register write and stays high until reset.
- R10: While `init_done`=0 the `ctl_*` inputs have no effect on the pins. While `init_done`=1 every pin equals its `ctl_*` input in the same cycle.
- R11: Every command the block issues is followed by a NOP in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_cas_lat | input | 3 | Read latency code for A6..A4 |
| mr_interleave | input | 1 | Burst ordering bit for A3 |
| mr_burst_len | input | 3 | Burst length code for A2..A0 |
| mr_single_write | input | 1 | Single-beat write bit for A9 |
| xm_enable | input | 1 | Issue the extended register write |
| xm_half_drive | input | 1 | Half output drive (A5) |
| xm_array_sel | input | 2 | Self-refresh array size select |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_cs_n | input | 1 | Controller chip select |
| ctl_ras_n | input | 1 | Controller row strobe |
| ctl_cas_n | input | 1 | Controller column strobe |
| ctl_we_n | input | 1 | Controller write enable |
| ctl_ba | input | 2 | Controller bank address |
| ctl_addr | input | AW | Controller address |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | AW | SDRAM address |
| init_done | output | 1 | Sequence complete, bus handed over |

## Verification
The checker enforces several rules on every cycle:
- clock enable stays high and only the four legal commands appear before `init_done`;
- every issued command is a single cycle;
- precharge-all carries A10;
- both register writes keep their reserved bits at zero;
- the extended array code is never a reserved one;
- `init_done` never falls.

Some behaviour only the bench scenarios can show, because it compares the pins against values worked out independently from the requirements:
- the exact cycle of each command;
- the refresh count;
- the contents of each register write for several settings;
- the absence of the extended write when it is disabled;
- the pass-through of the controller inputs once `init_done` is high;
- a clean restart after a reset in the middle of the sequence.

// File: rtl/sdbi_pkg.sv
package sdbi_pkg;

  // Command encoding as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    PH_HOLD,
    PH_PRE,
    PH_REF,
    PH_LMR,
    PH_XLMR,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic [2:0] lat;
    logic       interleave;
    logic [2:0] blen;
    logic       single_wr;
  } mode_cfg_t;

  typedef struct packed {
    logic       en;
    logic       half_drive;
    logic [1:0] array_sel;
  } xmode_cfg_t;

endpackage

// File: rtl/sdbi_fsm.sv
module sdbi_fsm
  import sdbi_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int REF_CNT    = 2,
  parameter int T_RP       = 3,
  parameter int T_RC       = 7,
  parameter int T_MRD      = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_en,
  output phase_t phase,
  output logic   done
);
  localparam int G1   = (STABLE_CYC > T_RP) ? STABLE_CYC : T_RP;
  localparam int G2   = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAXG = (G1 > G2) ? G1 : G2;
  localparam int CW   = $clog2(MAXG + 1);
  localparam int RW   = $clog2(REF_CNT + 1);

  logic [CW-1:0] left;
  logic [RW-1:0] refs;
  phase_t        nxt;

  // Every command state lasts one cycle, then PH_HOLD counts out the gap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HOLD;
      left  <= CW'(STABLE_CYC);
      nxt   <= PH_PRE;
      refs  <= RW'(REF_CNT);
    end else begin
      case (phase)
        PH_HOLD: begin
          if (left == CW'(1)) phase <= nxt;
          else                left  <= left - CW'(1);
        end
        PH_PRE: begin
          phase <= PH_HOLD;
          left  <= CW'(T_RP - 1);
          nxt   <= PH_REF;
        end
        PH_REF: begin
          phase <= PH_HOLD;
          left  <= CW'(T_RC - 1);
          refs  <= refs - RW'(1);
          nxt   <= (refs == RW'(1)) ? PH_LMR : PH_REF;
        end
        PH_LMR: begin
          phase <= PH_HOLD;
          left  <= CW'(T_MRD - 1);
          nxt   <= ext_en ? PH_XLMR : PH_DONE;
        end
        PH_XLMR: begin
          phase <= PH_HOLD;
          left  <= CW'(T_MRD - 1);
          nxt   <= PH_DONE;
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  assign done = (phase == PH_DONE);
endmodule

// File: rtl/sdbi_word.sv
module sdbi_word
  import sdbi_pkg::*;
#(
  parameter int AW = 12
) (
  input  phase_t          phase,
  input  mode_cfg_t       mcfg,
  input  xmode_cfg_t      xcfg,
  output cmd_t            cmd,
  output logic [1:0]      ba,
  output logic [AW-1:0]   addr
);
  logic [2:0] arr_code;

  always_comb begin
    case (xcfg.array_sel)
      2'd1:    arr_code = 3'b001;
      2'd2:    arr_code = 3'b010;
      default: arr_code = 3'b000;  // 0 and the reserved 3 both mean full array
    endcase
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 2'b00;
    addr = '0;
    case (phase)
      PH_PRE: begin
        cmd      = CMD_PRE;
        addr[10] = 1'b1;
      end
      PH_REF: cmd = CMD_REF;
      PH_LMR: begin
        cmd       = CMD_LMR;
        addr[9]   = mcfg.single_wr;
        addr[6:4] = mcfg.lat;
        addr[3]   = mcfg.interleave;
        addr[2:0] = mcfg.blen;
      end
      PH_XLMR: begin
        cmd       = CMD_LMR;
        ba        = 2'b10;
        addr[5]   = xcfg.half_drive;
        addr[2:0] = arr_code;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdbi_bus.sv
module sdbi_bus
  import sdbi_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          own_ctl,
  input  cmd_t          init_cmd,
  input  logic [1:0]    init_ba,
  input  logic [AW-1:0] init_addr,
  input  logic          ctl_cke,
  input  logic [3:0]    ctl_cmd,
  input  logic [1:0]    ctl_ba,
  input  logic [AW-1:0] ctl_addr,
  output logic          cke,
  output logic [3:0]    cmd_pins,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr
);
  always_comb begin
    if (own_ctl) begin
      cke      = ctl_cke;
      cmd_pins = ctl_cmd;
      ba       = ctl_ba;
      addr     = ctl_addr;
    end else begin
      cke      = 1'b1;
      cmd_pins = init_cmd;
      ba       = init_ba;
      addr     = init_addr;
    end
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdbi_pkg::*;
#(
  parameter int AW         = 12,
  parameter int STABLE_CYC = 20000,
  parameter int REF_CNT    = 2,
  parameter int T_RP       = 3,
  parameter int T_RC       = 7,
  parameter int T_MRD      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mr_cas_lat,
  input  logic          mr_interleave,
  input  logic [2:0]    mr_burst_len,
  input  logic          mr_single_write,
  input  logic          xm_enable,
  input  logic          xm_half_drive,
  input  logic [1:0]    xm_array_sel,
  input  logic          ctl_cke,
  input  logic          ctl_cs_n,
  input  logic          ctl_ras_n,
  input  logic          ctl_cas_n,
  input  logic          ctl_we_n,
  input  logic [1:0]    ctl_ba,
  input  logic [AW-1:0] ctl_addr,
  output logic          sd_cke,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic [1:0]    sd_ba,
  output logic [AW-1:0] sd_addr,
  output logic          init_done
);
  phase_t        phase;
  cmd_t          icmd;
  logic [1:0]    iba;
  logic [AW-1:0] iaddr;
  logic [3:0]    pins;
  mode_cfg_t     mcfg;
  xmode_cfg_t    xcfg;

  assign mcfg = '{lat: mr_cas_lat, interleave: mr_interleave,
                  blen: mr_burst_len, single_wr: mr_single_write};
  assign xcfg = '{en: xm_enable, half_drive: xm_half_drive,
                  array_sel: xm_array_sel};

  sdbi_fsm #(
    .STABLE_CYC(STABLE_CYC), .REF_CNT(REF_CNT),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ext_en(xcfg.en),
    .phase(phase), .done(init_done)
  );

  sdbi_word #(.AW(AW)) u_word (
    .phase(phase), .mcfg(mcfg), .xcfg(xcfg),
    .cmd(icmd), .ba(iba), .addr(iaddr)
  );

  sdbi_bus #(.AW(AW)) u_bus (
    .own_ctl(init_done), .init_cmd(icmd), .init_ba(iba), .init_addr(iaddr),
    .ctl_cke(ctl_cke), .ctl_cmd({ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n}),
    .ctl_ba(ctl_ba), .ctl_addr(ctl_addr),
    .cke(sd_cke), .cmd_pins(pins), .ba(sd_ba), .addr(sd_addr)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
endmodule

// File: rtl/sdbi_chk.sv
module sdbi_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sd_cke,
  input logic          sd_cs_n,
  input logic          sd_ras_n,
  input logic          sd_cas_n,
  input logic          sd_we_n,
  input logic [1:0]    sd_ba,
  input logic [AW-1:0] sd_addr,
  input logic          init_done
);
  logic [3:0] c;
  logic       is_nop, is_pre, is_lmr;
  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop = (c == 4'b0111);
  assign is_pre = (c == 4'b0010);
  assign is_lmr = (c == 4'b0000);

  // R1
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> sd_cke);

  // R10
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (is_nop || is_pre || is_lmr || c == 4'b0001));

  // R11
  one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !is_nop) |=> is_nop);

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && is_pre) |-> sd_addr[10]);

  // R5
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && is_lmr && sd_ba == 2'b00) |->
      (sd_addr[AW-1:10] == '0 && sd_addr[8:7] == 2'b00));

  // R6
  xmode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && is_lmr && sd_ba == 2'b10) |->
      ((sd_addr & ~AW'(12'h027)) == '0));

  // R7
  xmode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && is_lmr && sd_ba == 2'b10) |-> (sd_addr[2:0] <= 3'd2));

  // R4
  lmr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && is_lmr) |-> (sd_ba == 2'b00 || sd_ba == 2'b10));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind sdram_boot_seq sdbi_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;
  localparam int CLK_P = 10;
  localparam int AW = 12, S = 10, NREF = 3, TRP = 3, TRC = 5, TMRD = 2;
  localparam int C_PRE  = S;
  localparam int C_REF0 = S + TRP;
  localparam int C_LMR  = C_REF0 + NREF * TRC;
  localparam int C_XLMR = C_LMR + TMRD;
  localparam int NV = 5;
  // {en, half, arr[1:0], lat[2:0], bt, blen[2:0], sw, mode_word[11:0], xmode_word[11:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 3'd3, 1'b0, 3'd2, 1'b0, 12'h032, 12'h000},
    {1'b1, 1'b1, 2'd1, 3'd2, 1'b1, 3'd3, 1'b1, 12'h22B, 12'h021},
    {1'b1, 1'b0, 2'd2, 3'd1, 1'b0, 3'd7, 1'b0, 12'h017, 12'h002},
    {1'b1, 1'b1, 2'd3, 3'd3, 1'b1, 3'd0, 1'b0, 12'h038, 12'h020},
    {1'b0, 1'b1, 2'd2, 3'd2, 1'b0, 3'd1, 1'b1, 12'h221, 12'h000}
  };

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] mr_cas_lat = '0, mr_burst_len = '0;
  logic mr_interleave = 0, mr_single_write = 0;
  logic xm_enable = 0, xm_half_drive = 0;
  logic [1:0] xm_array_sel = '0;
  logic ctl_cke = 0, ctl_cs_n = 0, ctl_ras_n = 0, ctl_cas_n = 0, ctl_we_n = 1;
  logic [1:0] ctl_ba = 2'b11;
  logic [AW-1:0] ctl_addr = '1;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0] sd_ba;
  logic [AW-1:0] sd_addr;

  int total = 0, bad = 0;

  sdram_boot_seq #(.AW(AW), .STABLE_CYC(S), .REF_CNT(NREF),
                   .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .mr_cas_lat(mr_cas_lat),
    .mr_interleave(mr_interleave), .mr_burst_len(mr_burst_len),
    .mr_single_write(mr_single_write), .xm_enable(xm_enable),
    .xm_half_drive(xm_half_drive), .xm_array_sel(xm_array_sel),
    .ctl_cke(ctl_cke), .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n),
    .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_ba(ctl_ba),
    .ctl_addr(ctl_addr), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int c, input bit en);
    if (c == C_PRE) return 4'b0010;
    for (int i = 0; i < NREF; i++) if (c == C_REF0 + i * TRC) return 4'b0001;
    if (c == C_LMR) return 4'b0000;
    if (en && c == C_XLMR) return 4'b0000;
    return 4'b0111;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pins() == 4'b0111, "R1", "cmd in reset", pins(), 4'b0111);
    check(sd_cke == 1'b1, "R1", "cke in reset", sd_cke, 1);
    check(init_done == 1'b0, "R9", "done in reset", init_done, 0);
  endtask

  task automatic run_vec(input logic [35:0] v);
    bit en;
    int dcyc;
    string tag;
    logic [3:0] e;
    en = v[35];
    xm_enable = v[35]; xm_half_drive = v[34]; xm_array_sel = v[33:32];
    mr_cas_lat = v[31:29]; mr_interleave = v[28]; mr_burst_len = v[27:25];
    mr_single_write = v[24];
    ctl_cke = 0; {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n} = 4'b0001;
    ctl_ba = 2'b11; ctl_addr = '1;
    dcyc = (en ? C_XLMR : C_LMR) + TMRD;
    do_reset();
    rst_n = 1'b1;
    #1;
    for (int c = 0; c <= dcyc + 3; c++) begin
      if (c > 0) @(negedge clk);
      if (c >= dcyc) begin
        check(pins() == 4'b0001 && sd_cke == 1'b0, "R10", "pass-through",
              {sd_cke, pins()}, 5'b00001);
      end else begin
        e = exp_cmd(c, en);
        if (c < S) tag = "R1";
        else if (c == C_PRE) tag = "R2";
        else if (c == C_LMR) tag = "R4";
        else if (en && c == C_XLMR) tag = "R6";
        else if (!en && c == C_XLMR) tag = "R8";
        else if (e == 4'b0001) tag = "R3";
        else tag = "R11";
        check(pins() == e, tag, $sformatf("cmd cycle %0d", c), pins(), e);
        check(sd_cke == 1'b1, "R10", "cke ignored ctl", sd_cke, 1);
        if (c == C_PRE)
          check(sd_addr[10] == 1'b1, "R2", "A10 on precharge", sd_addr[10], 1);
        if (c == C_LMR) begin
          check(sd_ba == 2'b00, "R4", "mode bank", sd_ba, 0);
          check(sd_addr == v[23:12], "R5", "mode word", sd_addr, v[23:12]);
        end
        if (en && c == C_XLMR) begin
          check(sd_ba == 2'b10, "R6", "xmode bank", sd_ba, 2);
          check(sd_addr == v[11:0], (v[33:32] == 2'd3) ? "R7" : "R6",
                "xmode word", sd_addr, v[11:0]);
        end
      end
      check(init_done == (c >= dcyc), "R9", $sformatf("done cycle %0d", c),
            init_done, (c >= dcyc));
    end
    ctl_cke = 1; {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n} = 4'b0101;
    ctl_ba = 2'b01; ctl_addr = 12'h5A3;
    #1;
    check(sd_cke && pins() == 4'b0101 && sd_ba == 2'b01 && sd_addr == 12'h5A3,
          "R10", "follow ctl", sd_addr, 12'h5A3);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: done holds under changing controller traffic
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ctl_addr = AW'(k * 37);
      check(init_done == 1'b1, "R9", "done sticky", init_done, 1);
    end

    // R1 / R2: reset in the middle of refreshes restarts the sequence
    xm_enable = 1'b0;
    do_reset();
    rst_n = 1'b1;
    repeat (C_REF0 + 2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pins() == 4'b0111 && sd_cke, "R1", "mid reset cmd", pins(), 4'b0111);
    check(init_done == 1'b0, "R9", "mid reset done", init_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int c = 1; c <= C_PRE; c++) begin
      @(negedge clk);
      check(pins() == exp_cmd(c, 1'b0), (c == C_PRE) ? "R2" : "R1",
            $sformatf("restart cycle %0d", c), pins(), exp_cmd(c, 1'b0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule